// File: doc/BRIEF.md
# Floating-Point Status and Exception Unit

This block keeps the control and status word of a floating-point unit. The word holds a rounding-mode field, a denormal (flush-to-zero) control bit, and three five-bit exception fields: sticky-per-operation flags, cause and trap enables. When an arithmetic operation completes, the datapath presents its five exception indications. The block rewrites the flag field from them, copies the new flags into the cause field and requests a floating-point trap whenever a cause bit meets a set enable bit.

Software loads the word as a whole. Bits that are not writable read back as zero. The rounding and flush controls the datapath needs are decoded from the stored word. Compare results also pass through the block. An ordered equal or greater-than compare writes the condition bit. An unordered compare leaves the condition bit alone and runs the exception update instead.

Top module: `fp_status_unit`

## Requirements
- R1: On an update event the flag field (bits 6:2) is cleared and then loaded from `exc_in`. Within every five-bit field, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid.
- R2: On an update event where any indication is set, the cause field (bits 16:12) takes the new flag value.
- R3: When the new cause ANDed with the enable field (bits 11:7) is non-zero, `trap_req` is high for exactly the cycle in which the updated word becomes visible, and `trap_code` shows 0x120 in that cycle. At all other times `trap_code` is zero.
- R4: On an update event with no indication set, the cause field keeps its previous value and no trap is requested.
- R5: A load (`ld_en`) stores `ld_word` AND 0x0005FFFF. All other bits read as zero.
- R6: `round_zero` is high exactly when the stored rounding field (bits 1:0) equals 2'b01 (toward zero). Every other code means nearest-even.
- R7: `flush_zero` follows stored bit 18.
- R8: After reset the status word, `cond_bit`, `trap_req` and `trap_code` are all zero.
- R9: A load in the same cycle as an update event wins. The update is discarded and no trap is requested.
- R10: An ordered compare (`cmp_en` with `cmp_rel` 0 = less, 1 = equal, 2 = greater) sets `cond_bit` to whether the relation holds. `cmp_gt` = 0 tests equal and `cmp_gt` = 1 tests greater.
- R11: An unordered compare (`cmp_rel` = 3) leaves `cond_bit` unchanged and performs the R1-to-R4 update using `exc_in`.
- R12: An update event leaves the rounding field, the enable field and bit 18 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Software load of the status word |
| ld_word | input | 32 | Value to load |
| op_done | input | 1 | Arithmetic operation completed, `exc_in` valid |
| exc_in | input | 5 | Exception indications from the datapath |
| cmp_en | input | 1 | Compare result valid |
| cmp_gt | input | 1 | 0 = equal test, 1 = greater-than test |
| cmp_rel | input | 2 | Relation: 0 less, 1 equal, 2 greater, 3 unordered |
| stat_word | output | 32 | Stored control and status word |
| round_zero | output | 1 | Datapath rounds toward zero |
| flush_zero | output | 1 | Datapath flushes denormals |
| cond_bit | output | 1 | Condition bit |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_code | output | 12 | Exception code, valid with `trap_req` |

## Verification
Every cycle, the assertions check the following:
- after an update, the flag and cause fields agree with the indications;
- a load stores the masked value;
- the control fields survive an update;
- a trap is requested exactly when the update finds an enabled cause;
- the condition bit follows ordered compares and holds on unordered ones.

Some behaviours only the bench's sweeps show. These are the full cross of enable settings against indication patterns, including the retained cause after an indication-free operation. The sweeps also cover the one-cycle shape of the trap pulse against the following idle cycle, and the decoded rounding and flush outputs for every load pattern.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int WORD_W    = 32;
  localparam int NEXC      = 5;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = 7;
  localparam int CAUSE_LSB = 12;
  localparam int DN_BIT    = 18;
  localparam int CODE_W    = 12;

  localparam logic [WORD_W-1:0] WR_MASK   = 32'h0005_FFFF;
  localparam logic [1:0]        RM_ZERO   = 2'b01;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  function automatic logic [NEXC-1:0] get_field(input logic [WORD_W-1:0] w, input int lsb);
    logic [WORD_W-1:0] s;
    s = w >> lsb;
    return s[NEXC-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] put_field(input logic [WORD_W-1:0] w, input int lsb,
                                                  input logic [NEXC-1:0] v);
    logic [WORD_W-1:0] m;
    logic [WORD_W-1:0] x;
    m = {{(WORD_W-NEXC){1'b0}}, {NEXC{1'b1}}} << lsb;
    x = {{(WORD_W-NEXC){1'b0}}, v} << lsb;
    return (w & ~m) | x;
  endfunction
endpackage

// File: rtl/fpsc_flag_update.sv
module fpsc_flag_update
  import fpsc_pkg::*;
(
  input  logic [WORD_W-1:0] cur_word,
  input  logic [NEXC-1:0]   exc,
  output logic [WORD_W-1:0] nxt_word,
  output logic              any_exc,
  output logic              trap_hit
);
  logic [NEXC-1:0] new_flags;
  logic [NEXC-1:0] en_field;
  logic [NEXC-1:0] hit_bits;
  logic [WORD_W-1:0] w_flags;

  assign en_field = get_field(cur_word, EN_LSB);

  for (genvar i = 0; i < NEXC; i++) begin : g_bit
    assign new_flags[i] = exc[i];
    assign hit_bits[i]  = new_flags[i] & en_field[i];
  end

  assign any_exc  = |new_flags;
  assign trap_hit = any_exc & (|hit_bits);

  always_comb begin
    w_flags  = put_field(cur_word, FLAG_LSB, new_flags);
    nxt_word = any_exc ? put_field(w_flags, CAUSE_LSB, new_flags) : w_flags;
  end
endmodule

// File: rtl/fpsc_cmp_unit.sv
module fpsc_cmp_unit
  import fpsc_pkg::*;
(
  input  logic       cmp_en,
  input  logic       cmp_gt,
  input  logic [1:0] cmp_rel,
  output logic       cond_we,
  output logic       cond_val,
  output logic       unord
);
  rel_e rel;
  assign rel      = rel_e'(cmp_rel);
  assign unord    = cmp_en & (rel == REL_UN);
  assign cond_we  = cmp_en & (rel != REL_UN);
  assign cond_val = cmp_gt ? (rel == REL_GT) : (rel == REL_EQ);
endmodule

// File: rtl/fpsc_mode_decode.sv
module fpsc_mode_decode
  import fpsc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              rtz,
  output logic              ftz
);
  assign rtz = (word[1:0] == RM_ZERO);
  assign ftz = word[DN_BIT];
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              op_done,
  input  logic [NEXC-1:0]   exc_in,
  input  logic              cmp_en,
  input  logic              cmp_gt,
  input  logic [1:0]        cmp_rel,
  output logic [WORD_W-1:0] stat_word,
  output logic              round_zero,
  output logic              flush_zero,
  output logic              cond_bit,
  output logic              trap_req,
  output logic [CODE_W-1:0] trap_code
);
  logic [WORD_W-1:0] stat_q, stat_d, upd_word;
  logic cond_q, trap_q;
  logic any_exc, trap_hit;
  logic cond_we, cond_val, ev_unord;
  logic ev_load, ev_update;

  fpsc_flag_update u_upd (
    .cur_word(stat_q), .exc(exc_in), .nxt_word(upd_word),
    .any_exc(any_exc), .trap_hit(trap_hit)
  );

  fpsc_cmp_unit u_cmp (
    .cmp_en(cmp_en), .cmp_gt(cmp_gt), .cmp_rel(cmp_rel),
    .cond_we(cond_we), .cond_val(cond_val), .unord(ev_unord)
  );

  fpsc_mode_decode u_mode (
    .word(stat_q), .rtz(round_zero), .ftz(flush_zero)
  );

  assign ev_load   = ld_en;
  assign ev_update = (op_done | ev_unord) & ~ev_load;

  always_comb begin
    stat_d = stat_q;
    if (ev_load)        stat_d = ld_word & WR_MASK;
    else if (ev_update) stat_d = upd_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      cond_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      trap_q <= ev_update & trap_hit;
      if (cond_we) cond_q <= cond_val;
    end
  end

  assign stat_word = stat_q;
  assign cond_bit  = cond_q;
  assign trap_req  = trap_q;
  assign trap_code = trap_q ? TRAP_CODE : '0;

  a_r1_flags_from_exc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_update |=> get_field(stat_q, FLAG_LSB) == $past(exc_in));

  a_r2_cause_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_update && exc_in != '0) |=> get_field(stat_q, CAUSE_LSB) == $past(exc_in));

  a_r3_trap_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_update && ((exc_in & get_field(stat_q, EN_LSB)) != '0)) |=> trap_req);

  a_r3_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_code == TRAP_CODE &&
                  (get_field(stat_q, CAUSE_LSB) & get_field(stat_q, EN_LSB)) != '0));

  a_r4_no_exc_keeps_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_update && exc_in == '0) |=> ($stable(get_field(stat_q, CAUSE_LSB)) && !trap_req));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (stat_q == ($past(ld_word) & WR_MASK)) && !trap_req);

  a_r6_round_decode: assert property (@(posedge clk) disable iff (!rst_n)
    round_zero == (stat_word[1:0] == 2'b01));

  a_r10_ordered_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cmp_rel != 2'd3) |=>
      cond_bit == $past(cmp_gt ? (cmp_rel == 2'd2) : (cmp_rel == 2'd1)));

  a_r11_unordered_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cmp_rel == 2'd3) |=> $stable(cond_bit));

  a_r12_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_update |=> ($stable(stat_q[1:0]) && $stable(get_field(stat_q, EN_LSB)) &&
                   $stable(stat_q[DN_BIT])));
endmodule

// File: tb/fp_status_unit_test.sv
module fp_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_word = '0;
  logic        op_done = 1'b0;
  logic [4:0]  exc_in = '0;
  logic        cmp_en = 1'b0;
  logic        cmp_gt = 1'b0;
  logic [1:0]  cmp_rel = '0;
  logic [31:0] stat_word;
  logic        round_zero, flush_zero, cond_bit, trap_req;
  logic [11:0] trap_code;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fp_status_unit uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word),
    .op_done(op_done), .exc_in(exc_in), .cmp_en(cmp_en), .cmp_gt(cmp_gt),
    .cmp_rel(cmp_rel), .stat_word(stat_word), .round_zero(round_zero),
    .flush_zero(flush_zero), .cond_bit(cond_bit), .trap_req(trap_req),
    .trap_code(trap_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ld_en = 0; op_done = 0; cmp_en = 0; exc_in = '0;
  endtask

  task automatic load(input logic [31:0] w);
    ld_en = 1; ld_word = w;
    step();
    idle();
  endtask

  function automatic logic [31:0] mk(input logic [1:0] rm, input logic [4:0] fl,
                                     input logic [4:0] en, input logic [4:0] ca, input logic dn);
    return {13'd0, dn, 1'b0, ca, en, fl, rm};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] exp_w;
    logic        c_exp;
    @(negedge clk);
    step(); step();
    rst_n = 1;
    // R8 reset state
    chk("R8 word", stat_word, 32'd0);
    chk("R8 cond", {31'd0, cond_bit}, 32'd0);
    chk("R8 trap", {19'd0, trap_code, trap_req}, 32'd0);

    // R5 R6 R7 load sweep
    for (int k = 0; k < 16; k++) begin
      logic [31:0] v;
      v = (32'h9E37_79B9 * (k + 1)) ^ (k[0] ? 32'hFFFF_FFFF : 32'h0004_0000);
      v[1:0] = k[1:0];
      load(v);
      chk("R5 masked load", stat_word, v & 32'h0005_FFFF);
      chk("R6 round", {31'd0, round_zero}, {31'd0, v[1:0] == 2'b01});
      chk("R7 flush", {31'd0, flush_zero}, {31'd0, v[18]});
    end

    // R1 R2 R3 R4 R12 exhaustive enable x indication
    for (int en = 0; en < 32; en++) begin
      for (int ex = 0; ex < 32; ex++) begin
        logic [4:0] cexp;
        logic       t;
        load(mk(2'b01, 5'h1F, en[4:0], 5'h15, 1'b1));
        op_done = 1; exc_in = ex[4:0];
        step();
        idle();
        cexp  = (ex != 0) ? ex[4:0] : 5'h15;
        exp_w = mk(2'b01, ex[4:0], en[4:0], cexp, 1'b1);
        t     = (ex[4:0] & en[4:0]) != 0;
        chk("R1 R2 R4 R12 word", stat_word, exp_w);
        chk("R3 R4 trap", {31'd0, trap_req}, {31'd0, t});
        chk("R3 code", {20'd0, trap_code}, t ? 32'h120 : 32'h0);
        step();
        chk("R3 pulse width", {31'd0, trap_req}, 32'd0);
      end
    end

    // R9 load wins over simultaneous update
    load(mk(2'b00, 5'h00, 5'h1F, 5'h00, 1'b0));
    ld_en = 1; ld_word = 32'hFFFF_FFFC; op_done = 1; exc_in = 5'h1F;
    step();
    idle();
    chk("R9 load priority word", stat_word, 32'h0005_FFFC);
    chk("R9 no trap", {31'd0, trap_req}, 32'd0);

    // R10 ordered compares
    for (int init = 0; init < 2; init++) begin
      for (int g = 0; g < 2; g++) begin
        for (int r = 0; r < 3; r++) begin
          cmp_en = 1; cmp_gt = init[0]; cmp_rel = init[0] ? 2'd2 : 2'd0;
          step();
          idle();
          cmp_en = 1; cmp_gt = g[0]; cmp_rel = r[1:0];
          step();
          idle();
          c_exp = g[0] ? (r == 2) : (r == 1);
          chk("R10 cond", {31'd0, cond_bit}, {31'd0, c_exp});
        end
      end
    end

    // R11 unordered compare
    for (int init = 0; init < 2; init++) begin
      load(mk(2'b10, 5'h00, 5'h10, 5'h03, 1'b0));
      cmp_en = 1; cmp_gt = 1'b1; cmp_rel = init[0] ? 2'd2 : 2'd0;
      step();
      idle();
      cmp_en = 1; cmp_gt = 1'b0; cmp_rel = 2'd3; exc_in = 5'h10;
      step();
      idle();
      chk("R11 cond held", {31'd0, cond_bit}, {31'd0, init[0]});
      chk("R11 word", stat_word, mk(2'b10, 5'h10, 5'h10, 5'h10, 1'b0));
      chk("R11 trap", {20'd0, trap_code}, 32'h120);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule